// File: doc/BRIEF.md
# Hitless Reference-Switch Phase Corrector

This block sits between two reference clocks and a digital PLL. It works in a fast master-clock domain. Both references and the PLL feedback arrive as single-cycle edge pulses. A select input chooses which reference drives the PLL. When the choice changes, the block measures how far the first edge of the newly chosen reference lies ahead of the next feedback edge. It then delays every later edge of that reference by the measured amount. The virtual reference handed to the PLL therefore keeps the phase it had against the feedback before the changeover, and the loop sees no phase step.

A mode controller gates the correction through an enable input. With enable low the delay is zero, and the selected reference reaches the output one master cycle after it arrives. The reference rate is one of three settings: E1, T1 or 8 kHz. A rate code chooses it and sets the longest offset the measurement can record. A reset is required after the rate code changes.

Top module: `hitless_ref_corrector`

## Requirements
- R1: With ref_sel = 0 only primary pulses reach the output, and with ref_sel = 1 only secondary pulses do. Pulses of the unselected reference never produce an output pulse.
- R2: While the applied delay is zero, each accepted pulse of the selected reference yields one vref_pulse exactly one master cycle later.
- R3: With corr_en high, a change of ref_sel holds off the newly selected reference: none of its pulses reach the output until its measurement ends.
- R4: The measured offset is the number of master cycles from the first new-reference pulse (in or after the cycle of the change) to the first feedback pulse in or after that cycle. A feedback pulse in the same cycle gives zero.
- R5: The pulse that started a measurement leaves in the cycle after the measurement ends. Every later pulse leaves 1 + offset cycles after it arrives, so across a changeover the output shows no extra pulse and no missing pulse.
- R6: The measurement saturates at period − 1 master cycles. The period is E1_PER for freq_sel = 00, T1_PER for 01, and K8_PER for 10 or 11.
- R7: If ref_sel changes again before a measurement ends, that measurement is discarded and a new one starts on the next selected-reference pulse.
- R8: With corr_en low the applied delay is zero and no measurement runs, and a change of ref_sel switches source at once. The stored offset is kept, and it applies again when corr_en returns high, without a new measurement.
- R9: An active-low reset clears the stored offset and the measurement state, tracks the primary as the current source, and holds vref_pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_sel | input | 2 | Reference rate code: 00 E1, 01 T1, 1x 8 kHz |
| corr_en | input | 1 | Phase correction enable from the mode controller |
| ref_sel | input | 1 | Reference choice: 0 primary, 1 secondary |
| pri_pulse | input | 1 | Primary reference edge pulse |
| sec_pulse | input | 1 | Secondary reference edge pulse |
| fb_pulse | input | 1 | Feedback edge pulse from the PLL divider |
| vref_pulse | output | 1 | Virtual reference edge pulse to the PLL |

## Verification
The bench models a locked PLL: feedback keeps the phase of the output, and the secondary runs at a different phase. Every changeover is then checked cycle by cycle for an unbroken pulse train at the original phase. A design that let a new-reference pulse through early would show an extra pulse. One that dropped the pulse starting the measurement would leave a gap. An off-by-one in the counter would shift the train by a cycle. Further tests cover a changeover reversed mid-measurement, where a design that kept the stale count lands at the wrong phase. A missing feedback edge drives the count to saturation in all three rate settings, and a wrong period limit moves the output phase. An enable drop must zero the delay without losing the stored offset, and a design that re-measured or cleared the offset would come back at the wrong phase.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

  typedef enum logic [1:0] {
    MS_TRACK   = 2'd0,
    MS_ARMED   = 2'd1,
    MS_MEASURE = 2'd2
  } meas_state_e;

  localparam logic [1:0] RATE_E1 = 2'b00;
  localparam logic [1:0] RATE_T1 = 2'b01;

endpackage

// File: rtl/hrc_ref_mux.sv
module hrc_ref_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sel,
  input  logic pri_pulse,
  input  logic sec_pulse,
  output logic sel_pulse,
  output logic switch_evt
);

  logic sel_q;
  logic sel_d;

  assign sel_pulse  = ref_sel ? sec_pulse : pri_pulse;
  assign switch_evt = (ref_sel != sel_q);

  always_comb begin
    sel_d = ref_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

  // R9: after reset the tracked source is primary, so a held primary choice is no switch
  a_r9_tracks_primary: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !ref_sel) |-> !switch_evt);

endmodule

// File: rtl/hrc_phase_meter.sv
module hrc_phase_meter
  import hrc_pkg::*;
#(
  parameter int E1_PER = 16,
  parameter int T1_PER = 20,
  parameter int K8_PER = 64,
  parameter int CW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    freq_sel,
  input  logic          corr_en,
  input  logic          switch_evt,
  input  logic          ref_pulse,
  input  logic          fb_pulse,
  output logic          hold,
  output logic          meas_done,
  output logic [CW-1:0] dly_eff
);

  meas_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dly_q, dly_d;
  logic [CW-1:0] period;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (freq_sel)
      RATE_E1: period = CW'(E1_PER);
      RATE_T1: period = CW'(T1_PER);
      default: period = CW'(K8_PER);
    endcase
  end

  assign lim     = period - CW'(1);
  assign hold    = corr_en && (switch_evt || (state_q != MS_TRACK));
  assign dly_eff = corr_en ? dly_q : '0;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    dly_d     = dly_q;
    meas_done = 1'b0;
    if (!corr_en) begin
      state_d = MS_TRACK;
      cnt_d   = '0;
    end else if (switch_evt || (state_q == MS_ARMED)) begin
      cnt_d = '0;
      if (ref_pulse) begin
        if (fb_pulse) begin
          dly_d     = '0;
          meas_done = 1'b1;
          state_d   = MS_TRACK;
        end else begin
          state_d = MS_MEASURE;
          cnt_d   = CW'(1);
        end
      end else begin
        state_d = MS_ARMED;
      end
    end else if (state_q == MS_MEASURE) begin
      if (fb_pulse || (cnt_q >= lim)) begin
        dly_d     = cnt_q;
        meas_done = 1'b1;
        state_d   = MS_TRACK;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_TRACK;
      cnt_q   <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dly_q   <= dly_d;
    end
  end

  // R6: a running count never passes the saturation limit
  a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_MEASURE) |-> (cnt_q <= lim));

  // R6: the stored offset always fits inside one reference period
  a_r6_offset_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q < period);

  // R8: enable low leaves no measurement pending
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |=> (state_q == MS_TRACK));

  // R7: a select change under enable re-arms unless it completed on the spot
  a_r7_switch_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_en && switch_evt && !meas_done) |=> (state_q != MS_TRACK));

  // R4: the offset changes only when a measurement completes
  a_r4_offset_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(meas_done) |-> $stable(dly_q));

endmodule

// File: rtl/hrc_delay_line.sv
module hrc_delay_line #(
  parameter int NSLOT = 2,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          fire_any
);

  logic [NSLOT-1:0] active_vec;
  logic [NSLOT-1:0] fire;
  logic [NSLOT-1:0] pick;

  always_comb begin
    logic taken;
    taken = 1'b0;
    pick  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!taken && !active_vec[i]) begin
        pick[i] = 1'b1;
        taken   = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic          act_q, act_d;
    logic [CW-1:0] c_q, c_d;

    assign fire[i]       = act_q && (c_q == '0);
    assign active_vec[i] = act_q;

    always_comb begin
      act_d = act_q;
      c_d   = c_q;
      if (fire[i]) begin
        act_d = 1'b0;
      end else if (act_q) begin
        c_d = c_q - CW'(1);
      end
      if (load && pick[i]) begin
        act_d = 1'b1;
        c_d   = load_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        c_q   <= '0;
      end else begin
        act_q <= act_d;
        c_q   <= c_d;
      end
    end
  end

  assign fire_any = |fire;

  // R5: a delayed pulse always finds a free slot, so none is lost
  a_r5_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(&active_vec));

  // R5: two delayed pulses never merge into one output pulse
  a_r5_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

endmodule

// File: rtl/hitless_ref_corrector.sv
module hitless_ref_corrector #(
  parameter int E1_PER = 16,
  parameter int T1_PER = 20,
  parameter int K8_PER = 64,
  parameter int NSLOT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] freq_sel,
  input  logic       corr_en,
  input  logic       ref_sel,
  input  logic       pri_pulse,
  input  logic       sec_pulse,
  input  logic       fb_pulse,
  output logic       vref_pulse
);

  localparam int MAX_A   = (E1_PER > T1_PER) ? E1_PER : T1_PER;
  localparam int MAX_PER = (MAX_A > K8_PER) ? MAX_A : K8_PER;
  localparam int CW      = $clog2(MAX_PER + 1);

  logic          sel_pulse;
  logic          switch_evt;
  logic          hold;
  logic          meas_done;
  logic [CW-1:0] dly_eff;
  logic          accept;
  logic          direct;
  logic          load;
  logic          fire_any;
  logic          vref_d;
  logic          vref_q;

  hrc_ref_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_sel    (ref_sel),
    .pri_pulse  (pri_pulse),
    .sec_pulse  (sec_pulse),
    .sel_pulse  (sel_pulse),
    .switch_evt (switch_evt)
  );

  hrc_phase_meter #(
    .E1_PER (E1_PER),
    .T1_PER (T1_PER),
    .K8_PER (K8_PER),
    .CW     (CW)
  ) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_sel   (freq_sel),
    .corr_en    (corr_en),
    .switch_evt (switch_evt),
    .ref_pulse  (sel_pulse),
    .fb_pulse   (fb_pulse),
    .hold       (hold),
    .meas_done  (meas_done),
    .dly_eff    (dly_eff)
  );

  assign accept = sel_pulse && !hold;
  assign direct = accept && (dly_eff == '0);
  assign load   = accept && (dly_eff != '0);

  hrc_delay_line #(
    .NSLOT (NSLOT),
    .CW    (CW)
  ) u_dline (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (dly_eff - CW'(1)),
    .fire_any (fire_any)
  );

  always_comb begin
    vref_d = direct || meas_done || fire_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_q <= 1'b0;
    end else begin
      vref_q <= vref_d;
    end
  end

  assign vref_pulse = vref_q;

  // R3: a held-off reference pulse never enters the delay path
  a_r3_hold_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !load);

  // R5: a finished measurement releases its starting pulse one cycle later
  a_r5_done_emits: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> vref_pulse);

  // R2: with zero delay an accepted pulse appears on the next cycle
  a_r2_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pulse && !hold && !corr_en) |=> vref_pulse);

endmodule

// File: tb/test_hitless_ref_corrector.sv
module test_hitless_ref_corrector;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] freq_sel = 2'b00;
  logic       corr_en = 1'b1;
  logic       ref_sel = 1'b0;
  logic       pri_pulse = 1'b0;
  logic       sec_pulse = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       vref_pulse;

  int  k = 0;
  int  per = 16;
  int  pri_ph = 3;
  int  sec_ph = 10;
  int  fb_ph = 3;
  bit  fb_on = 1'b1;
  bit  logb [0:16383];
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  hitless_ref_corrector i_hitless_ref_corrector (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_sel   (freq_sel),
    .corr_en    (corr_en),
    .ref_sel    (ref_sel),
    .pri_pulse  (pri_pulse),
    .sec_pulse  (sec_pulse),
    .fb_pulse   (fb_pulse),
    .vref_pulse (vref_pulse)
  );

  // stimulus: periodic pulses keyed to the cycle index
  always @(negedge clk) begin
    pri_pulse = ((k % per) == pri_ph);
    sec_pulse = ((k % per) == sec_ph);
    fb_pulse  = fb_on && ((k % per) == fb_ph);
  end

  // log entry c: output high in cycle c+1, i.e. input cycle c plus delay
  always @(posedge clk) begin
    #1;
    if (vref_pulse && (k < 16384)) logb[k] = 1'b1;
    k++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic at_cycle(int c);
    wait (k == c);
    @(negedge clk);
  endtask

  // output pulses in [a,b) must be exactly the cycles congruent to ph (none if ph < 0)
  task automatic win(int a, int b, int ph, string req);
    int bad = -1;
    int act = 0;
    int exp = 0;
    wait (k >= b);
    for (int c = a; c < b; c++) begin
      bit e = (ph >= 0) && ((c % per) == ph);
      if ((logb[c] != e) && (bad < 0)) begin
        bad = c;
        act = logb[c];
        exp = e;
      end
    end
    chk(bad < 0, req, $sformatf("window [%0d,%0d) cycle %0d vref", a, b, bad), act, exp);
  endtask

  function automatic int next_at(int ph, int from);
    int c = from;
    while ((c % per) != ph) c++;
    return c;
  endfunction

  task automatic do_reset(logic [1:0] fs, int p);
    @(negedge clk);
    rst_n    = 1'b0;
    freq_sel = fs;
    per      = p;
    ref_sel  = 1'b0;
    corr_en  = 1'b1;
    for (int i = 0; i < 16384; i++) logb[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(vref_pulse == 1'b0, "R9", "output during reset", vref_pulse, 0);
    rst_n = 1'b1;
  endtask

  // R1, R2: primary passes one cycle late, secondary never appears
  task automatic t_passthrough();
    int a = k + 4;
    win(a, a + 64, pri_ph, "R2");
    win(a + 64, a + 96, pri_ph, "R1");
  endtask

  // R3, R4, R5: seamless switch to a secondary at another phase
  task automatic t_switch_seamless();
    int tp = next_at(pri_ph, k + 2);
    at_cycle(tp + 1);
    ref_sel = 1'b1;
    win(tp + 1, tp + 16, -1, "R3");
    win(tp + 16, tp + 17, fb_ph, "R4");
    win(tp, tp + 96, fb_ph, "R5");
  endtask

  // R4: switching back with feedback coincident measures zero
  task automatic t_switch_back();
    int tp = next_at(fb_ph, k + 2);
    at_cycle(tp + 1);
    ref_sel = 1'b0;
    win(tp, tp + 96, fb_ph, "R4");
  endtask

  // R7: reversal mid-measurement restarts on the primary
  task automatic t_abort();
    int tp = next_at(fb_ph, k + 2);
    at_cycle(tp + 1);
    ref_sel = 1'b1;
    at_cycle(tp + 9);
    ref_sel = 1'b0;
    win(tp, tp + 96, fb_ph, "R7");
  endtask

  // R6: no feedback, count saturates at period - 1
  task automatic t_saturate(string req);
    int tp;
    int t0;
    fb_on = 1'b0;
    tp = next_at(pri_ph, k + 2);
    at_cycle(tp + 1);
    ref_sel = 1'b1;
    t0 = tp + (sec_ph - pri_ph);
    win(tp + 1, t0 + per - 1, -1, "R3");
    win(t0 + per - 1, t0 + 4 * per, (sec_ph + per - 1) % per, req);
  endtask

  // R8: enable low zeroes delay, offset returns with enable, instant switch
  task automatic t_enable();
    int c = k + 2;
    int c2;
    int c3;
    at_cycle(c);
    corr_en = 1'b0;
    win(c + per, c + 4 * per, sec_ph, "R8");
    c2 = k + 2;
    at_cycle(c2);
    corr_en = 1'b1;
    win(c2 + per, c2 + 5 * per, (sec_ph + per - 1) % per, "R8");
    c3 = k + 2;
    at_cycle(c3);
    corr_en = 1'b0;
    ref_sel = 1'b0;
    win(c3 + per, c3 + 4 * per, pri_ph, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", k, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(2'b00, 16);
    fb_on = 1'b1;
    t_passthrough();
    t_switch_seamless();
    t_switch_back();
    t_abort();
    t_saturate("R6");
    t_enable();
    do_reset(2'b01, 20);
    t_saturate("R6");
    do_reset(2'b10, 64);
    t_saturate("R6");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule